// File: doc/BRIEF.md
# Interrupt Entry State Update Unit

This unit applies the architectural state changes made when an instruction-translation-miss interrupt is accepted. When the take strobe fires, it tells the pipeline to squash the faulting instruction in that same cycle. On the next clock edge it captures the faulting instruction's effective address and the old machine state into the two save/restore registers. It also writes a new machine state that keeps only three enable bits, and it issues a one-cycle fetch redirect to the vector address. That address is assembled from the prefix field of the vector prefix register and the offset field of the vector offset register assigned to this interrupt.

A return-from-interrupt strobe reverses the entry. It copies save/restore register 1 back into the machine state and redirects fetch to the address held in save/restore register 0. When both strobes arrive in the same cycle, the interrupt entry takes priority. The unit changes no architectural state besides its three registers.

Top module: `trap_entry_unit`

## Requirements
- R1: While the synchronous reset is high, the next clock edge clears `msr_o`, `srr0_o`, `srr1_o` and `redir_addr_o` to zero and drives `redir_vld_o` low.
- R2: `suppress_o` is high in exactly the cycles in which `take_i` is high, with no register on the path.
- R3: On the clock edge that samples `take_i` high, `srr0_o` is loaded with `fault_ea_i`.
- R4: On the clock edge that samples `take_i` high, `srr1_o` is loaded with the full `msr_i` value.
- R5: On the clock edge that samples `take_i` high, `msr_o` takes bits 17 (critical enable), 12 (machine-check enable) and 9 (debug enable) from `msr_i`, which is mask 0x00021200, and every other bit becomes 0.
- R6: In the cycle after a take, `redir_vld_o` is high and `redir_addr_o` equals `{vec_prefix_i, vec_offset_i, 4'b0000}`: the prefix in bits 31:16, the offset in bits 15:4 and zero in bits 3:0.
- R7: On an edge that samples `rfi_i` high and `take_i` low, `msr_o` is loaded with `srr1_o`, and `srr0_o` and `srr1_o` keep their values. In the next cycle `redir_vld_o` is high and `redir_addr_o` equals the `srr0_o` value from before the edge.
- R8: When `take_i` and `rfi_i` are both high in the same cycle, the result is exactly that of a take alone (R3 to R6).
- R9: On an edge at which neither strobe is high, `msr_o`, `srr0_o` and `srr1_o` hold their values and `redir_vld_o` is low in the following cycle, so each redirect is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take_i | input | 1 | Take the translation-miss interrupt this cycle |
| rfi_i | input | 1 | Return from interrupt this cycle |
| fault_ea_i | input | 32 | Effective address of the faulting instruction |
| msr_i | input | 32 | Machine state in force at the faulting instruction |
| vec_prefix_i | input | 16 | Prefix field of the vector prefix register |
| vec_offset_i | input | 12 | Offset field of this interrupt's vector offset register |
| suppress_o | output | 1 | Squash the faulting instruction |
| srr0_o | output | 32 | Save/restore register 0 |
| srr1_o | output | 32 | Save/restore register 1 |
| msr_o | output | 32 | Machine state register |
| redir_vld_o | output | 1 | Fetch redirect pulse |
| redir_addr_o | output | 32 | Fetch redirect address |

## Verification
The assertions assume the strobes and data inputs are known, never X, at every sampled edge after reset. They also assume reset is held across at least one edge at the start. They place no limit on how often the strobes arrive, so they also cover back-to-back takes and overlapping take and return strobes. The stimulus changes inputs only on the falling edge, keeps every input driven with defined values from time zero, holds reset for three edges, and mixes idle cycles, single strobes, consecutive strobes and simultaneous strobes.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    // Default geometry of the unit
    localparam int DEF_ADDR_W  = 32;
    localparam int DEF_MSR_W   = 32;
    localparam int DEF_PFX_LSB = 16;
    localparam int DEF_OFS_LSB = 4;

    // Default positions of the three preserved enable bits
    localparam int DEF_CRIT_POS = 17;
    localparam int DEF_MCHK_POS = 12;
    localparam int DEF_DBG_POS  = 9;

    // Event chosen for the current cycle
    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_TAKE   = 2'd1,
        EV_RETURN = 2'd2
    } trap_ev_e;

    // Priority: entry beats return
    function automatic trap_ev_e pick_event(input logic take, input logic ret);
        if (take)
            return EV_TAKE;
        else if (ret)
            return EV_RETURN;
        else
            return EV_NONE;
    endfunction

endpackage

// File: rtl/trap_event_arb.sv
module trap_event_arb
    import trap_entry_pkg::*;
(
    input  logic     take_i,
    input  logic     rfi_i,
    output trap_ev_e ev_o,
    output logic     suppress_o
);
    always_comb begin
        ev_o       = pick_event(take_i, rfi_i);
        suppress_o = take_i;
    end
endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen #(
    parameter int ADDR_W  = 32,
    parameter int PFX_LSB = 16,
    parameter int OFS_LSB = 4,
    localparam int PFX_W  = ADDR_W - PFX_LSB,
    localparam int OFS_W  = PFX_LSB - OFS_LSB
) (
    input  logic [PFX_W-1:0]  prefix_i,
    input  logic [OFS_W-1:0]  offset_i,
    output logic [ADDR_W-1:0] vec_o
);
    assign vec_o = {prefix_i, offset_i, {OFS_LSB{1'b0}}};
endmodule

// File: rtl/trap_msr_mask.sv
module trap_msr_mask #(
    parameter int MSR_W    = 32,
    parameter int CRIT_POS = 17,
    parameter int MCHK_POS = 12,
    parameter int DBG_POS  = 9
) (
    input  logic [MSR_W-1:0] msr_i,
    output logic [MSR_W-1:0] msr_entry_o
);
    for (genvar b = 0; b < MSR_W; b++) begin : g_bit
        localparam bit KEEP = (b == CRIT_POS) || (b == MCHK_POS) || (b == DBG_POS);
        assign msr_entry_o[b] = KEEP ? msr_i[b] : 1'b0;
    end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_entry_pkg::*;
#(
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int MSR_W    = DEF_MSR_W,
    parameter int PFX_LSB  = DEF_PFX_LSB,
    parameter int OFS_LSB  = DEF_OFS_LSB,
    parameter int CRIT_POS = DEF_CRIT_POS,
    parameter int MCHK_POS = DEF_MCHK_POS,
    parameter int DBG_POS  = DEF_DBG_POS,
    localparam int PFX_W   = ADDR_W - PFX_LSB,
    localparam int OFS_W   = PFX_LSB - OFS_LSB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_i,
    input  logic              rfi_i,
    input  logic [ADDR_W-1:0] fault_ea_i,
    input  logic [MSR_W-1:0]  msr_i,
    input  logic [PFX_W-1:0]  vec_prefix_i,
    input  logic [OFS_W-1:0]  vec_offset_i,
    output logic              suppress_o,
    output logic [ADDR_W-1:0] srr0_o,
    output logic [MSR_W-1:0]  srr1_o,
    output logic [MSR_W-1:0]  msr_o,
    output logic              redir_vld_o,
    output logic [ADDR_W-1:0] redir_addr_o
);
    trap_ev_e          ev;
    logic [ADDR_W-1:0] vec_addr;
    logic [MSR_W-1:0]  msr_entry;

    trap_event_arb u_arb (
        .take_i     (take_i),
        .rfi_i      (rfi_i),
        .ev_o       (ev),
        .suppress_o (suppress_o)
    );

    trap_vector_gen #(
        .ADDR_W  (ADDR_W),
        .PFX_LSB (PFX_LSB),
        .OFS_LSB (OFS_LSB)
    ) u_vec (
        .prefix_i (vec_prefix_i),
        .offset_i (vec_offset_i),
        .vec_o    (vec_addr)
    );

    trap_msr_mask #(
        .MSR_W    (MSR_W),
        .CRIT_POS (CRIT_POS),
        .MCHK_POS (MCHK_POS),
        .DBG_POS  (DBG_POS)
    ) u_mask (
        .msr_i       (msr_i),
        .msr_entry_o (msr_entry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            srr0_o       <= '0;
            srr1_o       <= '0;
            msr_o        <= '0;
            redir_vld_o  <= 1'b0;
            redir_addr_o <= '0;
        end else begin
            redir_vld_o <= 1'b0;
            case (ev)
                EV_TAKE: begin
                    srr0_o       <= fault_ea_i;
                    srr1_o       <= msr_i;
                    msr_o        <= msr_entry;
                    redir_vld_o  <= 1'b1;
                    redir_addr_o <= vec_addr;
                end
                EV_RETURN: begin
                    msr_o        <= srr1_o;
                    redir_vld_o  <= 1'b1;
                    redir_addr_o <= srr0_o;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/trap_entry_unit_chk.sv
module trap_entry_unit_chk #(
    parameter int ADDR_W   = 32,
    parameter int MSR_W    = 32,
    parameter int PFX_LSB  = 16,
    parameter int OFS_LSB  = 4,
    parameter int CRIT_POS = 17,
    parameter int MCHK_POS = 12,
    parameter int DBG_POS  = 9,
    localparam int PFX_W   = ADDR_W - PFX_LSB,
    localparam int OFS_W   = PFX_LSB - OFS_LSB
) (
    input logic              clk,
    input logic              rst,
    input logic              take_i,
    input logic              rfi_i,
    input logic [ADDR_W-1:0] fault_ea_i,
    input logic [MSR_W-1:0]  msr_i,
    input logic [PFX_W-1:0]  vec_prefix_i,
    input logic [OFS_W-1:0]  vec_offset_i,
    input logic              suppress_o,
    input logic [ADDR_W-1:0] srr0_o,
    input logic [MSR_W-1:0]  srr1_o,
    input logic [MSR_W-1:0]  msr_o,
    input logic              redir_vld_o,
    input logic [ADDR_W-1:0] redir_addr_o
);
    localparam logic [MSR_W-1:0] ONE  = {{(MSR_W-1){1'b0}}, 1'b1};
    localparam logic [MSR_W-1:0] KEEP = (ONE << CRIT_POS) | (ONE << MCHK_POS) | (ONE << DBG_POS);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (msr_o == '0 && srr0_o == '0 && srr1_o == '0 && !redir_vld_o));

    // R2
    suppress_match_chk: assert property (@(posedge clk) disable iff (rst)
        suppress_o == take_i);

    // R3
    srr0_load_chk: assert property (@(posedge clk) disable iff (rst)
        take_i |=> srr0_o == $past(fault_ea_i));

    // R4
    srr1_load_chk: assert property (@(posedge clk) disable iff (rst)
        take_i |=> srr1_o == $past(msr_i));

    // R5
    msr_entry_chk: assert property (@(posedge clk) disable iff (rst)
        take_i |=> ((msr_o & ~KEEP) == '0) && ((msr_o & KEEP) == ($past(msr_i) & KEEP)));

    // R6
    vector_redir_chk: assert property (@(posedge clk) disable iff (rst)
        take_i |=> redir_vld_o && redir_addr_o == {$past(vec_prefix_i), $past(vec_offset_i), {OFS_LSB{1'b0}}});

    // R7
    return_restore_chk: assert property (@(posedge clk) disable iff (rst)
        (rfi_i && !take_i) |=> msr_o == $past(srr1_o) && redir_vld_o
                               && redir_addr_o == $past(srr0_o) && $stable(srr0_o) && $stable(srr1_o));

    // R8
    take_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (rfi_i && take_i) |=> srr0_o == $past(fault_ea_i) && srr1_o == $past(msr_i));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rfi_i && !take_i) |=> !redir_vld_o && $stable(msr_o) && $stable(srr0_o) && $stable(srr1_o));
endmodule

bind trap_entry_unit trap_entry_unit_chk #(
    .ADDR_W   (ADDR_W),
    .MSR_W    (MSR_W),
    .PFX_LSB  (PFX_LSB),
    .OFS_LSB  (OFS_LSB),
    .CRIT_POS (CRIT_POS),
    .MCHK_POS (MCHK_POS),
    .DBG_POS  (DBG_POS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .take_i       (take_i),
    .rfi_i        (rfi_i),
    .fault_ea_i   (fault_ea_i),
    .msr_i        (msr_i),
    .vec_prefix_i (vec_prefix_i),
    .vec_offset_i (vec_offset_i),
    .suppress_o   (suppress_o),
    .srr0_o       (srr0_o),
    .srr1_o       (srr1_o),
    .msr_o        (msr_o),
    .redir_vld_o  (redir_vld_o),
    .redir_addr_o (redir_addr_o)
);

// File: tb/trap_entry_unit_test.sv
`timescale 1ns/1ps
module trap_entry_unit_test;
    localparam logic [31:0] KEEP = 32'h0002_1200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        take_i = 1'b0;
    logic        rfi_i = 1'b0;
    logic [31:0] fault_ea_i = '0;
    logic [31:0] msr_i = '0;
    logic [15:0] vec_prefix_i = '0;
    logic [11:0] vec_offset_i = '0;
    logic        suppress_o;
    logic [31:0] srr0_o, srr1_o, msr_o, redir_addr_o;
    logic        redir_vld_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        bit          vld;
        logic [31:0] addr;
        logic [31:0] srr0;
        logic [31:0] srr1;
        logic [31:0] msr;
        string       tag;
    } exp_t;

    exp_t sb[$];

    // Bench reference state
    logic [31:0] m_srr0 = '0, m_srr1 = '0, m_msr = '0;

    always #2 clk = ~clk;

    trap_entry_unit uut (
        .clk          (clk),
        .rst          (rst),
        .take_i       (take_i),
        .rfi_i        (rfi_i),
        .fault_ea_i   (fault_ea_i),
        .msr_i        (msr_i),
        .vec_prefix_i (vec_prefix_i),
        .vec_offset_i (vec_offset_i),
        .suppress_o   (suppress_o),
        .srr0_o       (srr0_o),
        .srr1_o       (srr1_o),
        .msr_o        (msr_o),
        .redir_vld_o  (redir_vld_o),
        .redir_addr_o (redir_addr_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected result
    task automatic drive(input bit take, input bit ret, input logic [31:0] ea,
                         input logic [31:0] msr, input logic [15:0] pfx,
                         input logic [11:0] ofs, input string tag);
        exp_t e;
        @(negedge clk);
        take_i = take; rfi_i = ret; fault_ea_i = ea; msr_i = msr;
        vec_prefix_i = pfx; vec_offset_i = ofs;
        e.vld = 1'b0; e.addr = '0;
        if (take) begin
            m_srr0 = ea; m_srr1 = msr; m_msr = msr & KEEP;
            e.vld = 1'b1; e.addr = {pfx, ofs, 4'b0000};
        end else if (ret) begin
            e.vld = 1'b1; e.addr = m_srr0; m_msr = m_srr1;
        end
        e.srr0 = m_srr0; e.srr1 = m_srr1; e.msr = m_msr; e.tag = tag;
        sb.push_back(e);
        #0.5;
        chk({"R2 suppress ", tag}, {31'b0, suppress_o}, {31'b0, take});
    endtask

    // Monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                chk({"R6/R9 redirect valid ", e.tag}, {31'b0, redir_vld_o}, {31'b0, e.vld});
                if (e.vld) chk({"R6/R7 redirect address ", e.tag}, redir_addr_o, e.addr);
                chk({"R3 srr0 ", e.tag}, srr0_o, e.srr0);
                chk({"R4 srr1 ", e.tag}, srr1_o, e.srr1);
                chk({"R5 msr ", e.tag}, msr_o, e.msr);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 msr", msr_o, 32'h0);
        chk("R1 srr0", srr0_o, 32'h0);
        chk("R1 srr1", srr1_o, 32'h0);
        chk("R1 redirect", {31'b0, redir_vld_o}, 32'h0);
        chk("R1 redirect address", redir_addr_o, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        drive(0, 0, 32'h1111_1111, 32'hFFFF_FFFF, 16'hAAAA, 12'h555, "R9 idle");
        // R5 all ones keeps only the three enables
        drive(1, 0, 32'h0000_4004, 32'hFFFF_FFFF, 16'hFFF0, 12'h0E0, "R5 take ones");
        drive(0, 0, 32'h0, 32'h0, 16'h0, 12'h0, "R9 hold after take");
        // R5 all bits except enables: msr becomes zero
        drive(1, 0, 32'hDEAD_BEE0, 32'hFFFD_EDFF, 16'h1234, 12'hABC, "R5 take others");
        // R7 return restores previous machine state and srr0 address
        drive(0, 1, 32'h0, 32'h0, 16'h0, 12'h0, "R7 return");
        drive(0, 1, 32'h0, 32'h0, 16'h0, 12'h0, "R7 second return");
        // R8 simultaneous strobes
        drive(1, 1, 32'h0BAD_F00C, 32'h0002_0201, 16'h8001, 12'hFFF, "R8 both strobes");
        drive(1, 0, 32'h7777_0008, 32'h0000_1000, 16'h0000, 12'h001, "R3 back to back take");
        drive(0, 1, 32'h0, 32'h0, 16'h0, 12'h0, "R7 return after take");
        drive(0, 0, 32'h0, 32'h0, 16'h0, 12'h0, "R9 idle after return");
        for (int i = 0; i < 200; i++) begin
            logic [31:0] r;
            r = $urandom;
            drive(r[0] & r[1], r[2], $urandom, $urandom, 16'($urandom), 12'($urandom), "R6 mixed");
        end
        drive(0, 0, 32'h0, 32'h0, 16'h0, 12'h0, "R9 final idle");
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule